// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block derives the clock for a memory card from the peripheral clock. A single 32-bit control word is written over a simple register bus. The word selects how far the peripheral clock is divided, whether the card clock runs at all, and four timeout selections. The block stores those four selections and passes them on to a command engine. It does not time anything with them itself.

A 4-bit exponent code n in the control word divides the peripheral clock by 2^(n+1). Every divided ratio has equal high and low halves. One reserved code sends the peripheral clock straight through, but only if a strap input permits it. Every other reserved code falls back to the slowest ratio.

Software may rewrite the word at any time. A new ratio, mode or enable value is applied only at a moment when the card clock is low, so the output never carries a shortened pulse.

Top module: `cclk_gen`

## Requirements
- R1: After synchronous reset, the control word reads back as 0, the card clock is low, and all four timeout outputs are 0.
- R2: A write at byte offset 0x18 stores the full 32-bit word, and a read at 0x18 returns it. A write at any other offset changes nothing, and a read at any other offset returns 0.
- R3: The timeout outputs copy control bits unchanged: response from bits 13:12, busy from bits 11:8, data from bits 7:4 and completion signal from bits 3:0.
- R4: With bit 24 set and code n = bits 19:16 in the range 0 to 8, the card clock's high phase and low phase each last 2^n peripheral cycles.
- R5: While the applied enable (bit 24) is 0, the card clock stays low.
- R6: Codes 9 to 14 give high and low phases of 256 peripheral cycles each.
- R7: Code 15 with the bypass strap at 1 and bit 24 set drives the card clock high during every high half of the peripheral clock and low during every low half. Leaving this mode returns to clean divided phases.
- R8: Code 15 with the strap at 0 gives high and low phases of 256 peripheral cycles.
- R9: A code change made while the card clock is high leaves that high phase and the following low phase at the old length. The next high phase uses the new ratio.
- R10: Clearing bit 24 while the card clock is high lets that high phase finish at its full length, and the clock then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_byp | input | 1 | Permits the pass-through code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| card_clk | output | 1 | Card clock |
| to_resp | output | 2 | Response timeout select |
| to_busy | output | 4 | Busy timeout select |
| to_data | output | 4 | Read/write data timeout select |
| to_ccs | output | 4 | Completion-signal timeout select |

## Verification
Every legal code from 0 to 8 is run, and the high and low phase lengths are measured in steady state. A run-length error at any exponent shows up this way. Reserved codes 9 and 14, and code 15 with the strap both low and high, separate the fallback decode from the pass-through path. Rewrites made in the middle of a high phase, one changing the ratio and one clearing the enable, show whether a change is applied at the safe moment or too early. A write to a neighbouring offset shows that the decode rejects other addresses.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
   localparam int CTRL_W   = 32;
   localparam int EN_BIT   = 24;
   localparam int CODE_LSB = 16;
   localparam logic [3:0] PASS_CODE = 4'hF;

   typedef struct packed {
      logic       en;
      logic       byp;
      logic [3:0] exp;
   } cclk_cfg_t;

   // Map a code to an effective exponent, clamping reserved codes to the top.
   function automatic logic [3:0] clamp_exp(input logic [3:0] code,
                                            input logic [3:0] top);
      return (code <= top) ? code : top;
   endfunction
endpackage

// File: rtl/cclk_regs.sv
module cclk_regs
   import cclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_OFF = 'h18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CTRL_W-1:0] rd_data,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [1:0]        to_resp,
   output logic [3:0]        to_busy,
   output logic [3:0]        to_data,
   output logic [3:0]        to_ccs
);
   logic hit_wr;
   logic hit_rd;

   assign hit_wr = wr_en && (wr_addr == REG_OFF);
   assign hit_rd = (rd_addr == REG_OFF);

   always_ff @(posedge clk) begin
      if (rst)
         ctrl_q <= '0;
      else if (hit_wr)
         ctrl_q <= wr_data;
   end

   assign rd_data = hit_rd ? ctrl_q : '0;
   assign to_resp = ctrl_q[13:12];
   assign to_busy = ctrl_q[11:8];
   assign to_data = ctrl_q[7:4];
   assign to_ccs  = ctrl_q[3:0];
endmodule

// File: rtl/cclk_apply.sv
module cclk_apply
   import cclk_pkg::*;
#(
   parameter int MAX_EXP   = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic              strap_byp,
   input  logic              div_q,
   input  logic              tc,
   output cclk_cfg_t         app,
   output logic              take,
   output logic              rise_ok
);
   localparam logic [3:0] TOP_EXP = 4'(MAX_EXP);

   cclk_cfg_t req;
   logic      run_old;
   logic      run_new;
   logic [3:0] code;

   assign code    = ctrl_q[CODE_LSB +: 4];
   assign req.en  = ctrl_q[EN_BIT];
   assign req.byp = BYPASS_EN && strap_byp && (code == PASS_CODE);
   assign req.exp = req.byp ? 4'd0 : clamp_exp(code, TOP_EXP);

   assign run_old = app.en && !app.byp;
   assign run_new = req.en && !req.byp;

   // Changes are applied only while the divided output is low: either it is
   // idle, or the low phase is ending at this edge.
   assign take    = !div_q && (!run_old || tc);
   assign rise_ok = run_old && tc && run_new;

   always_ff @(posedge clk) begin
      if (rst)
         app <= '0;
      else if (take)
         app <= req;
   end
endmodule

// File: rtl/cclk_divider.sv
module cclk_divider
   import cclk_pkg::*;
#(
   parameter int MAX_EXP = 8
) (
   input  logic      clk,
   input  logic      rst,
   input  cclk_cfg_t app,
   input  logic      take,
   input  logic      rise_ok,
   output logic      div_q,
   output logic      tc
);
   localparam int CNT_W = MAX_EXP;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   half;
   logic             running;

   assign half    = (CNT_W+1)'(1) << app.exp;
   assign tc      = ({1'b0, cnt} == (half - 1'b1));
   assign running = app.en && !app.byp;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         div_q <= 1'b0;
      end else if (take) begin
         cnt   <= '0;
         div_q <= rise_ok;
      end else if (running) begin
         if (tc) begin
            cnt   <= '0;
            div_q <= ~div_q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt   <= '0;
         div_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cclk_gate.sv
module cclk_gate
   import cclk_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  cclk_cfg_t app,
   input  logic      div_q,
   output logic      byp_gate,
   output logic      card_clk
);
   generate
      if (BYPASS_EN) begin : g_pass
         // Gate changes on the falling edge, while the peripheral clock is low.
         always_ff @(negedge clk) begin
            if (rst)
               byp_gate <= 1'b0;
            else
               byp_gate <= app.en && app.byp;
         end
         assign card_clk = (clk & byp_gate) | div_q;
      end else begin : g_nopass
         assign byp_gate = 1'b0;
         assign card_clk = div_q;
      end
   endgenerate
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
   import cclk_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_OFF = 'h18,
   parameter int MAX_EXP   = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strap_byp,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              card_clk,
   output logic [1:0]        to_resp,
   output logic [3:0]        to_busy,
   output logic [3:0]        to_data,
   output logic [3:0]        to_ccs
);
   generate
      if (MAX_EXP < 1 || MAX_EXP > 14) begin : g_bad_exp
         $error("cclk_gen: MAX_EXP must lie in 1..14");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("cclk_gen: ADDR_W too narrow for the register offset");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   cclk_cfg_t         app_cfg;
   logic              take;
   logic              rise_ok;
   logic              div_q;
   logic              tc;
   logic              byp_gate;

   cclk_regs #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ctrl_q(ctrl_q), .to_resp(to_resp), .to_busy(to_busy),
      .to_data(to_data), .to_ccs(to_ccs)
   );

   cclk_apply #(.MAX_EXP(MAX_EXP), .BYPASS_EN(BYPASS_EN)) u_apply (
      .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .strap_byp(strap_byp),
      .div_q(div_q), .tc(tc), .app(app_cfg), .take(take), .rise_ok(rise_ok)
   );

   cclk_divider #(.MAX_EXP(MAX_EXP)) u_div (
      .clk(clk), .rst(rst), .app(app_cfg), .take(take),
      .rise_ok(rise_ok), .div_q(div_q), .tc(tc)
   );

   cclk_gate #(.BYPASS_EN(BYPASS_EN)) u_gate (
      .clk(clk), .rst(rst), .app(app_cfg), .div_q(div_q),
      .byp_gate(byp_gate), .card_clk(card_clk)
   );
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk #(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_OFF = 'h18,
   parameter int MAX_EXP = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [31:0]       rd_data,
   input logic [1:0]        to_resp,
   input logic [3:0]        to_busy,
   input logic [3:0]        to_data,
   input logic [3:0]        to_ccs,
   input logic              app_en,
   input logic [3:0]        app_exp,
   input logic              div_q,
   input logic              byp_gate
);
   logic [MAX_EXP+1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         hi_cnt <= '0;
      else if (div_q)
         hi_cnt <= hi_cnt + 1'b1;
      else
         hi_cnt <= '0;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) && !rst |-> !div_q && to_resp == 2'd0 && to_busy == 4'd0
                            && to_data == 4'd0 && to_ccs == 4'd0);

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && wr_addr == REG_OFF) && rd_addr == REG_OFF
      |-> rd_data == $past(wr_data));

   // R3
   timeout_out_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && wr_addr == REG_OFF)
      |-> to_busy == $past(wr_data[11:8]) && to_resp == $past(wr_data[13:12])
          && to_data == $past(wr_data[7:4]) && to_ccs == $past(wr_data[3:0]));

   // R4
   high_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(div_q) |-> hi_cnt == ((MAX_EXP+2)'(1) << app_exp));

   // R5
   off_low_chk: assert property (@(posedge clk) disable iff (rst)
      !app_en |-> !div_q);

   // R7
   path_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(div_q && byp_gate));

   // R9
   high_stable_chk: assert property (@(posedge clk) disable iff (rst)
      div_q && $past(div_q) |-> $stable(app_exp) && $stable(app_en));
endmodule

bind cclk_gen cclk_gen_chk #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .MAX_EXP(MAX_EXP)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_addr(rd_addr), .rd_data(rd_data), .to_resp(to_resp), .to_busy(to_busy),
   .to_data(to_data), .to_ccs(to_ccs), .app_en(app_cfg.en),
   .app_exp(app_cfg.exp), .div_q(div_q), .byp_gate(byp_gate)
);

// File: tb/sim_cclk_gen.sv
`timescale 1ns/1ps
module sim_cclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 150000;
   localparam logic [7:0] OFF = 8'h18;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strap_byp = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        card_clk;
   logic [1:0]  to_resp;
   logic [3:0]  to_busy, to_data, to_ccs;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   cclk_gen u0 (
      .clk(clk), .rst(rst), .strap_byp(strap_byp), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .card_clk(card_clk), .to_resp(to_resp),
      .to_busy(to_busy), .to_data(to_data), .to_ccs(to_ccs)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_LIMIT) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WDOG_LIMIT);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input bit en, input int code);
      return (32'(en) << 24) | (32'(code & 15) << 16);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // Sample at falling edges; wait for a fresh rising phase.
   task automatic sync_rise(output bit ok);
      int g;
      ok = 1'b0;
      for (g = 0; g < 4000; g++) begin
         @(negedge clk);
         if (!card_clk) break;
      end
      for (g = 0; g < 4000; g++) begin
         @(negedge clk);
         if (card_clk) begin ok = 1'b1; break; end
      end
   endtask

   task automatic count_level(input logic lvl, input int start, output int n);
      n = start;
      for (int g = 0; g < 4000; g++) begin
         @(negedge clk);
         if (card_clk == lvl) n++;
         else break;
      end
   endtask

   // Measure the second complete high/low pair after sync.
   task automatic measure(output int hi, output int lo);
      bit ok;
      sync_rise(ok);
      count_level(1'b1, 1, hi);
      count_level(1'b0, 1, lo);
      count_level(1'b1, 1, hi);
      count_level(1'b0, 1, lo);
      if (!ok) begin hi = -1; lo = -1; end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(OFF, d);
      chk(d == 32'd0, "R1", "ctrl after reset", d, 0);
      @(negedge clk);
      chk(card_clk == 1'b0, "R1", "card_clk after reset", card_clk, 0);
      chk({to_resp, to_busy, to_data, to_ccs} == 14'd0, "R1", "timeouts after reset",
          {to_resp, to_busy, to_data, to_ccs}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(OFF, 32'h00A5_3C96);
      rd(OFF, d);
      chk(d == 32'h00A5_3C96, "R2", "readback", d, 32'h00A5_3C96);
      chk(to_resp == 2'b11, "R3", "resp timeout", to_resp, 2'b11);
      chk(to_busy == 4'hC, "R3", "busy timeout", to_busy, 4'hC);
      chk(to_data == 4'h9, "R3", "data timeout", to_data, 4'h9);
      chk(to_ccs == 4'h6, "R3", "ccs timeout", to_ccs, 4'h6);
      wr(8'h10, 32'hDEAD_BEEF);
      rd(OFF, d);
      chk(d == 32'h00A5_3C96, "R2", "other offset write ignored", d, 32'h00A5_3C96);
      rd(8'h10, d);
      chk(d == 32'd0, "R2", "other offset reads zero", d, 0);
      chk(to_busy == 4'hC, "R2", "timeouts kept after stray write", to_busy, 4'hC);
   endtask

   task automatic t_ratios();
      int hi, lo;
      for (int n = 0; n <= 8; n++) begin
         wr(OFF, word(1'b1, n));
         measure(hi, lo);
         chk(hi == (1 << n), "R4", $sformatf("high phase code %0d", n), hi, 1 << n);
         chk(lo == (1 << n), "R4", $sformatf("low phase code %0d", n), lo, 1 << n);
      end
   endtask

   task automatic t_reserved();
      int hi, lo;
      wr(OFF, word(1'b1, 9));
      measure(hi, lo);
      chk(hi == 256 && lo == 256, "R6", "code 9 phases", hi * 1000 + lo, 256256);
      wr(OFF, word(1'b1, 14));
      measure(hi, lo);
      chk(hi == 256 && lo == 256, "R6", "code 14 phases", hi * 1000 + lo, 256256);
   endtask

   task automatic t_strap_off();
      int hi, lo;
      strap_byp = 1'b0;
      wr(OFF, word(1'b1, 15));
      measure(hi, lo);
      chk(hi == 256 && lo == 256, "R8", "code 15 strap low", hi * 1000 + lo, 256256);
   endtask

   task automatic t_bypass();
      int hi, lo;
      int miss;
      strap_byp = 1'b1;
      wr(OFF, word(1'b1, 15));
      repeat (600) @(negedge clk);
      miss = 0;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk); #1;
         if (card_clk !== 1'b1) miss++;
         @(negedge clk); #1;
         if (card_clk !== 1'b0) miss++;
      end
      chk(miss == 0, "R7", "pass-through follows clock", miss, 0);
      wr(OFF, word(1'b1, 2));
      measure(hi, lo);
      chk(hi == 4 && lo == 4, "R7", "divided after pass-through", hi * 1000 + lo, 4004);
      strap_byp = 1'b0;
   endtask

   task automatic t_change();
      bit ok;
      int hi, lo;
      wr(OFF, word(1'b1, 3));
      measure(hi, lo);
      sync_rise(ok);
      wr(OFF, word(1'b1, 1));
      count_level(1'b1, 3, hi);
      chk(ok && hi == 8, "R9", "high phase during change", hi, 8);
      count_level(1'b0, 1, lo);
      chk(lo == 8, "R9", "low phase after change", lo, 8);
      count_level(1'b1, 1, hi);
      chk(hi == 2, "R9", "first new high phase", hi, 2);
      count_level(1'b0, 1, lo);
      chk(lo == 2, "R9", "first new low phase", lo, 2);
   endtask

   task automatic t_disable();
      bit ok;
      int hi, highs;
      wr(OFF, word(1'b0, 0));
      highs = 0;
      repeat (100) begin
         @(negedge clk);
         if (card_clk) highs++;
      end
      chk(highs == 0, "R5", "disabled clock stays low", highs, 0);
      wr(OFF, word(1'b1, 3));
      measure(hi, hi);
      sync_rise(ok);
      wr(OFF, word(1'b0, 3));
      count_level(1'b1, 3, hi);
      chk(ok && hi == 8, "R10", "high phase completes on disable", hi, 8);
      highs = 0;
      repeat (600) begin
         @(negedge clk);
         if (card_clk) highs++;
      end
      chk(highs == 0, "R10", "low after disable", highs, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_regs();
      t_ratios();
      t_reserved();
      t_strap_off();
      t_bypass();
      t_change();
      t_disable();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule